// File: doc/BRIEF.md
# Address Decoder with Programmable Wait States

This block sits between a processor with a 16-bit address bus and three slave devices: a boot ROM, a UART and a RAM. It produces one active-low select for each device. The selects are pure combinational logic on the two top address bits. The ROM occupies the lowest quarter of the space, the UART the second quarter and the RAM the upper half. Exactly one select is low at any time.

The block also drives a registered WAIT output that stretches the processor's bus cycle. When a bus cycle begins, the processor pulses the strobe for one clock. The block then latches the wait count that belongs to the region the address falls in. WAIT stays high for exactly that many clocks. Every region has its own 3-bit count, and reset sets every count to the maximum of 7. Software can reduce a count through a small write port. A new count applies from the next strobe onward, so a bus cycle that is already running keeps its length.

Top module: `bus_select_wait`

## Requirements
- R1: `rom_sel_n` is low exactly when address bits 15 and 14 are both 0 (0x0000–0x3FFF).
- R2: `uart_sel_n` is low exactly when address bit 15 is 0 and bit 14 is 1 (0x4000–0x7FFF).
- R3: `ram_sel_n` is low exactly when address bit 15 is 1 (0x8000–0xFFFF).
- R4: Exactly one of the three selects is low for every address value.
- R5: After reset, all three regions use a wait count of 7. The first strobe into any region therefore holds WAIT high for 7 clocks.
- R6: A strobe sampled at a clock edge loads the count of the region that the address decodes to at that edge. WAIT is high after that edge and stays high for exactly N clock periods, where N is the loaded count. WAIT never rises without a strobe.
- R7: When the loaded count is 0, WAIT stays low for the whole bus cycle.
- R8: A strobe that arrives while WAIT is high restarts the count with the count of the new address's region.
- R9: A configuration write does not change the length of the bus cycle already in progress. This includes a write at the same edge as the strobe. The written value applies from the next strobe onward.
- R10: A configuration write selects its region by code: 0 for ROM, 1 for UART, 2 for RAM. A write with code 3 changes no count.
- R11: While reset is active, WAIT is low. After reset, WAIT stays low until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| cyc_start | input | 1 | One-clock pulse marking the start of a bus cycle |
| cfg_we | input | 1 | Write enable for the wait-count port |
| cfg_sel | input | 2 | Region code for the write (0 ROM, 1 UART, 2 RAM) |
| cfg_val | input | 3 | New wait count |
| rom_sel_n | output | 1 | ROM select, active low |
| uart_sel_n | output | 1 | UART select, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| wait_o | output | 1 | Bus-cycle stretch request, registered |

## Verification
The assertions check on every cycle:
- each select agrees with the address bits and exactly one select is low;
- a strobe with a non-zero count raises WAIT and a zero count keeps it low;
- WAIT never rises without a strobe;
- a write with region code 3 leaves the stored counts unchanged.

The bench scenarios cover what a single-cycle property cannot: the exact number of WAIT cycles for every region and every count, the reset values of the counts, a restart while WAIT is high, and a configuration write landing inside a running bus cycle.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_UART = 2'd1,
        RGN_RAM  = 2'd2
    } region_e;
endpackage

// File: rtl/bsw_region_decode.sv
module bsw_region_decode
    import bsw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              rom_sel_n,
    output logic              uart_sel_n,
    output logic              ram_sel_n
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        if (addr[TOP]) begin
            region = RGN_RAM;
        end else if (addr[TOP-1]) begin
            region = RGN_UART;
        end else begin
            region = RGN_ROM;
        end
        rom_sel_n  = ~(~addr[TOP] & ~addr[TOP-1]);
        uart_sel_n = ~(~addr[TOP] &  addr[TOP-1]);
        ram_sel_n  = ~addr[TOP];
    end
endmodule

// File: rtl/bsw_wait_cfg.sv
module bsw_wait_cfg #(
    parameter int CNT_W   = 3,
    parameter int NUM_RGN = 3,
    parameter int SEL_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [CNT_W-1:0]           val,
    output logic [NUM_RGN*CNT_W-1:0]   counts
);
    localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_RGN-1:0][CNT_W-1:0] cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (we && (int'(sel) == i)) begin
                cfg_d.cnt[i] = val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.cnt <= {NUM_RGN{MAX_CNT}};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_out
        assign counts[g*CNT_W +: CNT_W] = cfg_q.cnt[g];
    end

    // R10: an out-of-range region code leaves every count untouched
    assert_bad_sel_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(sel) >= NUM_RGN) |=> $stable(counts));
endmodule

// File: rtl/bsw_wait_gen.sv
module bsw_wait_gen #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             wait_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wt;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (start) begin
            gen_d.cnt = load_val;
            gen_d.wt  = (load_val != '0);
        end else if (gen_q.cnt != '0) begin
            gen_d.cnt = gen_q.cnt - 1'b1;
            gen_d.wt  = (gen_d.cnt != '0);
        end else begin
            gen_d.wt  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign wait_o = gen_q.wt;

    // R6: a strobe with a non-zero count raises WAIT on the next edge
    assert_wait_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load_val != '0) |=> wait_o);
    // R7: a zero count keeps WAIT low
    assert_zero_no_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load_val == '0) |=> !wait_o);
    // R6: WAIT cannot rise without a strobe
    assert_no_spurious_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wait_o) |=> !wait_o);
endmodule

// File: rtl/bus_select_wait.sv
module bus_select_wait
    import bsw_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 3,
    parameter int SEL_W   = 2,
    parameter int NUM_RGN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cyc_start,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CNT_W-1:0]  cfg_val,
    output logic              rom_sel_n,
    output logic              uart_sel_n,
    output logic              ram_sel_n,
    output logic              wait_o
);
    localparam int TOP = ADDR_W - 1;

    region_e                   region;
    logic [NUM_RGN*CNT_W-1:0]  counts;
    logic [CNT_W-1:0]          load_val;

    bsw_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr       (addr),
        .region     (region),
        .rom_sel_n  (rom_sel_n),
        .uart_sel_n (uart_sel_n),
        .ram_sel_n  (ram_sel_n)
    );

    bsw_wait_cfg #(.CNT_W(CNT_W), .NUM_RGN(NUM_RGN), .SEL_W(SEL_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .val    (cfg_val),
        .counts (counts)
    );

    always_comb begin
        load_val = counts[int'(region)*CNT_W +: CNT_W];
    end

    bsw_wait_gen #(.CNT_W(CNT_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .load_val (load_val),
        .wait_o   (wait_o)
    );

    // R4: exactly one select is low
    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_sel_n, uart_sel_n, ram_sel_n}) == 2);
    // R1: ROM select only in the lowest quarter
    assert_rom_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel_n |-> (addr[TOP:TOP-1] == 2'b00));
    // R2: UART select only in the second quarter
    assert_uart_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_sel_n |-> (addr[TOP:TOP-1] == 2'b01));
    // R3: RAM select only in the upper half
    assert_ram_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> addr[TOP]);
endmodule

// File: tb/sim_bus_select_wait.sv
module sim_bus_select_wait;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        cyc_start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_val = '0;
    logic        rom_sel_n, uart_sel_n, ram_sel_n, wait_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] base [3] = '{16'h0000, 16'h4000, 16'h8000};

    always #5 clk = ~clk;

    bus_select_wait u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cyc_start(cyc_start),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
        .rom_sel_n(rom_sel_n), .uart_sel_n(uart_sel_n), .ram_sel_n(ram_sel_n),
        .wait_o(wait_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic write_cfg(input int sel, input int val);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_val = 3'(val);
        step();
        cfg_we = 1'b0;
    endtask

    // strobe, then count the clocks WAIT stays high after the strobe edge
    task automatic measure(input logic [15:0] a, output int n);
        addr = a; cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
        n = 0;
        while (wait_o && n < 20) begin
            n++;
            step();
        end
    endtask

    initial begin
        int n;
        int exp_cnt [3];
        // R11: reset state
        step(); step();
        check(wait_o == 1'b0, "R11 wait in reset", int'(wait_o), 0);
        rst_n = 1'b1;
        step(); step(); step();
        check(wait_o == 1'b0, "R11 wait after reset without strobe", int'(wait_o), 0);

        // R1 R2 R3 R4: full address sweep
        for (int a = 0; a < 65536; a++) begin
            int k;
            bit er1, er2, er3, bad;
            addr = 16'(a);
            #1;
            k = a >> 14;
            bad = 1'b0;
            er1 = (k == 0); er2 = (k == 1); er3 = (k >= 2);
            if (rom_sel_n  != !er1) begin bad = 1'b1; check(0, "R1 rom select", int'(rom_sel_n), int'(!er1)); end
            if (uart_sel_n != !er2) begin bad = 1'b1; check(0, "R2 uart select", int'(uart_sel_n), int'(!er2)); end
            if (ram_sel_n  != !er3) begin bad = 1'b1; check(0, "R3 ram select", int'(ram_sel_n), int'(!er3)); end
            if ((a & 16'h0FFF) == 0)
                check(!bad && ({rom_sel_n, uart_sel_n, ram_sel_n} != 3'b111) &&
                      (int'(rom_sel_n) + int'(uart_sel_n) + int'(ram_sel_n) == 2),
                      "R4 one select", int'(rom_sel_n) + int'(uart_sel_n) + int'(ram_sel_n), 2);
            if (bad) break;
        end

        // R5: reset counts are all 7
        for (int r = 0; r < 3; r++) begin
            measure(base[r] + 16'h0123, n);
            check(n == 7, "R5 reset count", n, 7);
        end

        // R6 R7: every region, every count
        for (int r = 0; r < 3; r++) begin
            for (int v = 0; v < 8; v++) begin
                write_cfg(r, v);
                measure(base[r] + 16'(v * 16'h0567), n);
                if (v == 0) check(n == 0, "R7 zero count", n, 0);
                else        check(n == v, "R6 wait length", n, v);
            end
        end

        // R8: restart during a running wait
        write_cfg(0, 6);
        write_cfg(2, 2);
        addr = 16'h1000; cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
        step(); step();
        check(wait_o == 1'b1, "R8 wait running before restart", int'(wait_o), 1);
        measure(16'hC000, n);
        check(n == 2, "R8 restart with ram count", n, 2);

        // R9: write at strobe edge leaves the running cycle alone
        write_cfg(0, 5);
        addr = 16'h2000; cyc_start = 1'b1;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_val = 3'd1;
        step();
        cyc_start = 1'b0; cfg_we = 1'b0;
        n = 0;
        while (wait_o && n < 20) begin n++; step(); end
        check(n == 5, "R9 same-edge write ignored", n, 5);
        measure(16'h2000, n);
        check(n == 1, "R9 write applies next cycle", n, 1);
        // R9: write in the middle of a wait
        write_cfg(1, 4);
        addr = 16'h5000; cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
        n = 1;
        write_cfg(1, 7);
        while (wait_o && n < 20) begin n++; step(); end
        check(n == 4, "R9 mid-wait write ignored", n, 4);
        measure(16'h5000, n);
        check(n == 7, "R9 mid-wait write applies next", n, 7);

        // R10: region code 3 changes nothing
        write_cfg(0, 3); write_cfg(1, 2); write_cfg(2, 6);
        exp_cnt = '{3, 2, 6};
        write_cfg(3, 0);
        for (int r = 0; r < 3; r++) begin
            measure(base[r] + 16'h0040, n);
            check(n == exp_cnt[r], "R10 code 3 ignored", n, exp_cnt[r]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule